// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a memory-mapped bank of board status and control words for a small SoC. It answers a 32-bit APB-style register bus inside a 4 KB window. It holds a board identifier, an LED output word, two general configuration words, and two flag words. Each flag word has one address that sets bits and another that clears bits, and the set address also reads the word back. A set of fixed identification words and a range of placeholder offsets are decoded as well. The placeholders read as zero and ignore writes.

A reset-control word is protected by a key register. Writes to the reset-control word land only while the key register holds one exact 16-bit magic value, 0xA05F. An accepted write with bit 8 set produces a one-cycle system reset request. Two resets are provided. The normal synchronous reset clears everything except the non-volatile flags. A separate power-on reset clears every register, including those flags.

A bus transfer always takes a setup cycle followed by an access cycle. Read data is captured into a register at the setup edge. Writes commit at the access edge.

Top module: `sysreg_bank`

## Requirements
- R1: While either reset is high, and after both are released, the registers hold these values: ID (0x000) reads the BOARD_ID parameter, flags (0x030) read 3, and LED, key, configuration and reset-control words read 0. The outputs `reset_req` and `addr_err` are low and `led_out` is 0.
- R2: `prdata` is loaded at the setup edge of a read (psel=1, penable=0, pwrite=0) and holds its value through the access cycle. A write commits at the access edge (psel=1, penable=1, pwrite=1).
- R3: Offset 0x008 is a read/write LED word, and `led_out` always shows its stored value.
- R4: Offsets 0x028 and 0x02C are independent read/write configuration words.
- R5: A write to the key register at 0x020 whose full 32-bit data equals 0x0000A05F stores 0xA05F. Any other written value stores data bits 14:0, with bit 15 forced to 0. Reads return the stored 16-bit value, zero-extended.
- R6: A write to reset control at 0x040 is stored only while the key register holds exactly 0xA05F. In every other key state the write is ignored and the old value reads back.
- R7: `reset_req` is high for exactly one cycle, in the cycle after the access edge of an accepted reset-control write with data bit 8 set. It stays low for an ignored write and for an accepted write with bit 8 clear.
- R8: A write to 0x030 ORs the data into the flags word. A write to 0x034 clears the flag bits that are 1 in the data. Reads at 0x030 return the flags.
- R9: Non-volatile flags follow the same rules, with 0x038 to set and read and 0x03C to clear. They reset to 0 only on `por_rst`; `rst` leaves them unchanged.
- R10: Fixed words read as follows: 0x044 reads 1, 0x050 reads 0x1000, 0x084 reads 0x02000000 and 0x088 reads 0xFF000000. Placeholder offsets (0x004, 0x00C–0x01C, 0x024, 0x048–0x04C, 0x054–0x074, 0x080, 0x08C–0x09C, 0x0C0–0x0D0), the clear addresses on read, and writes to any fixed or placeholder word read 0 or change nothing, and they raise no error.
- R11: Any other offset, or any address with bits 1:0 not zero, reads 0 and ignores writes. For such an access `addr_err` is high for exactly the one cycle after its access edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high; non-volatile flags kept |
| por_rst | input | 1 | Synchronous power-on reset, active high; clears everything |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address within the window |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Registered read data |
| led_out | output | DATA_W | Current LED word |
| reset_req | output | 1 | One-cycle system reset request |
| addr_err | output | 1 | One-cycle pulse for an access to an unmapped or misaligned address |

## Verification
The key logic is tried with four kinds of value:
- a plain value, which shows the stored value is kept;
- a value with bit 15 set, which shows the forced-zero bit;
- the magic value with upper bits set, which shows that only an exact 32-bit match unlocks;
- the exact key.

Reset-control writes are made while locked, while unlocked with bit 8 set and with bit 8 clear, and after relocking. This separates "stored" from "pulsed".

The flag words receive overlapping set and clear patterns, so OR and AND-NOT cannot be confused with plain stores. Each reset is pulsed alone, which shows that only the power-on reset clears the non-volatile word.

The address cases are a placeholder, a gap offset and a misaligned address. These tell a harmless zero read apart from an error pulse, and show that neither one disturbs a real register.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int WIN_ADDR_W = 12;
  localparam int IDX_W      = WIN_ADDR_W - 2;

  typedef enum logic [3:0] {
    SEL_ID,
    SEL_LED,
    SEL_KEY,
    SEL_CFG_A,
    SEL_CFG_B,
    SEL_FLG_SET,
    SEL_FLG_CLR,
    SEL_NVF_SET,
    SEL_NVF_CLR,
    SEL_RSTCTL,
    SEL_CONST,
    SEL_NONE
  } sel_e;

  // Word-index decode of the 4 KB window
  function automatic sel_e decode_word(input logic [IDX_W-1:0] idx);
    sel_e s;
    case (idx)
      10'h000: s = SEL_ID;
      10'h002: s = SEL_LED;
      10'h008: s = SEL_KEY;
      10'h00A: s = SEL_CFG_A;
      10'h00B: s = SEL_CFG_B;
      10'h00C: s = SEL_FLG_SET;
      10'h00D: s = SEL_FLG_CLR;
      10'h00E: s = SEL_NVF_SET;
      10'h00F: s = SEL_NVF_CLR;
      10'h010: s = SEL_RSTCTL;
      10'h001, 10'h003, 10'h004, 10'h005, 10'h006, 10'h007, 10'h009,
      10'h011, 10'h012, 10'h013, 10'h014, 10'h015, 10'h016, 10'h017,
      10'h018, 10'h019, 10'h01A, 10'h01B, 10'h01C, 10'h01D, 10'h020,
      10'h021, 10'h022, 10'h023, 10'h024, 10'h025, 10'h026, 10'h027,
      10'h030, 10'h031, 10'h032, 10'h033, 10'h034: s = SEL_CONST;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Read value of fixed and placeholder words
  function automatic logic [31:0] const_word(input logic [IDX_W-1:0] idx);
    logic [31:0] v;
    case (idx)
      10'h011: v = 32'h0000_0001;
      10'h014: v = 32'h0000_1000;
      10'h021: v = 32'h0200_0000;
      10'h022: v = 32'hFF00_0000;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [DATA_W-1:0] const_val
);
  localparam int IW = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             in_window;

  generate
    if (IW >= IDX_W) begin : g_wide
      assign idx = addr[IDX_W+1:2];
      if (IW > IDX_W) begin : g_hi
        assign in_window = (addr[ADDR_W-1:IDX_W+2] == '0);
      end else begin : g_eq
        assign in_window = 1'b1;
      end
    end else begin : g_narrow
      assign idx       = IDX_W'(addr[ADDR_W-1:2]);
      assign in_window = 1'b1;
    end
  endgenerate

  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    sel       = SEL_NONE;
    const_val = '0;
    if (aligned && in_window) begin
      sel       = decode_word(idx);
      const_val = DATA_W'(const_word(idx));
    end
  end
endmodule

// File: rtl/sysreg_key.sv
module sysreg_key #(
  parameter int          DATA_W = 32,
  parameter int          KEY_W  = 16,
  parameter logic [15:0] KEY    = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [KEY_W-1:0]  key_q,
  output logic              unlocked
);
  localparam logic [KEY_W-1:0] KEY_V = KEY_W'(KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
    end else if (wr_en) begin
      if (wdata == DATA_W'(KEY_V)) key_q <= KEY_V;
      else                         key_q <= {1'b0, wdata[KEY_W-2:0]};
    end
  end

  assign unlocked = (key_q == KEY_V);

  // A stored top bit can only come from the exact key
  assert_key_form_R5: assert property (@(posedge clk) disable iff (rst)
    key_q[KEY_W-1] |-> (key_q == KEY_V));

  // Non-key write never leaves the block unlocked
  assert_key_relock_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata != DATA_W'(KEY_V)) |=> !unlocked);
endmodule

// File: rtl/sysreg_flags.sv
module sysreg_flags #(
  parameter int              DATA_W    = 32,
  parameter logic [31:0]     RESET_VAL = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= DATA_W'(RESET_VAL);
    else if (set_en) q <= q | wdata;
    else if (clr_en) q <= q & ~wdata;
  end

  assert_flags_clr_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> ((q & $past(wdata)) == '0));

  assert_flags_set_R8: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((q & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] BOARD_ID  = 32'h0178_0500,
  parameter logic [31:0] FLAG_INIT = 32'h0000_0003,
  parameter logic [15:0] LOCK_KEY  = 16'hA05F,
  parameter int          KEY_W     = 16,
  parameter int          RST_BIT   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic [DATA_W-1:0] led_out,
  output logic              reset_req,
  output logic              addr_err
);
  logic              rst_any;
  sel_e              sel;
  logic [DATA_W-1:0] const_val;
  logic              access, wr_fire, rd_setup;
  logic [KEY_W-1:0]  key_q;
  logic              unlocked;
  logic [DATA_W-1:0] led_q, cfg_a_q, cfg_b_q, rstctl_q;
  logic [DATA_W-1:0] flg_q, nvf_q;
  logic [DATA_W-1:0] rd_val;
  logic              rst_accept;

  assign rst_any  = rst | por_rst;
  assign access   = psel & penable;
  assign wr_fire  = access & pwrite & ~rst_any;
  assign rd_setup = psel & ~penable & ~pwrite;

  sysreg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr      (paddr),
    .sel       (sel),
    .const_val (const_val)
  );

  sysreg_key #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(LOCK_KEY)) u_key (
    .clk      (clk),
    .rst      (rst_any),
    .wr_en    (wr_fire && sel == SEL_KEY),
    .wdata    (pwdata),
    .key_q    (key_q),
    .unlocked (unlocked)
  );

  sysreg_flags #(.DATA_W(DATA_W), .RESET_VAL(FLAG_INIT)) u_flg (
    .clk    (clk),
    .rst    (rst_any),
    .set_en (wr_fire && sel == SEL_FLG_SET),
    .clr_en (wr_fire && sel == SEL_FLG_CLR),
    .wdata  (pwdata),
    .q      (flg_q)
  );

  sysreg_flags #(.DATA_W(DATA_W), .RESET_VAL(32'h0)) u_nvf (
    .clk    (clk),
    .rst    (por_rst),
    .set_en (wr_fire && sel == SEL_NVF_SET),
    .clr_en (wr_fire && sel == SEL_NVF_CLR),
    .wdata  (pwdata),
    .q      (nvf_q)
  );

  // Plain read/write words
  always_ff @(posedge clk) begin
    if (rst_any) begin
      led_q   <= '0;
      cfg_a_q <= '0;
      cfg_b_q <= '0;
    end else if (wr_fire) begin
      if (sel == SEL_LED)   led_q   <= pwdata;
      if (sel == SEL_CFG_A) cfg_a_q <= pwdata;
      if (sel == SEL_CFG_B) cfg_b_q <= pwdata;
    end
  end

  // Guarded reset control and request pulse
  assign rst_accept = wr_fire && (sel == SEL_RSTCTL) && unlocked;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      rstctl_q  <= '0;
      reset_req <= 1'b0;
    end else begin
      if (rst_accept) rstctl_q <= pwdata;
      reset_req <= rst_accept & pwdata[RST_BIT];
    end
  end

  // Read mux, registered at the setup edge
  always_comb begin
    case (sel)
      SEL_ID:      rd_val = DATA_W'(BOARD_ID);
      SEL_LED:     rd_val = led_q;
      SEL_KEY:     rd_val = DATA_W'(key_q);
      SEL_CFG_A:   rd_val = cfg_a_q;
      SEL_CFG_B:   rd_val = cfg_b_q;
      SEL_FLG_SET: rd_val = flg_q;
      SEL_NVF_SET: rd_val = nvf_q;
      SEL_RSTCTL:  rd_val = rstctl_q;
      SEL_CONST:   rd_val = const_val;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      prdata   <= '0;
      addr_err <= 1'b0;
    end else begin
      if (rd_setup) prdata <= rd_val;
      addr_err <= access && (sel == SEL_NONE);
    end
  end

  assign led_out = led_q;

  assert_rstreq_pulse_R7: assert property (@(posedge clk) disable iff (rst_any)
    reset_req |=> !reset_req);

  assert_rstreq_cause_R7: assert property (@(posedge clk) disable iff (rst_any)
    reset_req |-> $past(unlocked && pwdata[RST_BIT] && psel && penable && pwrite));

  assert_rstctl_guard_R6: assert property (@(posedge clk) disable iff (rst_any)
    !unlocked |=> $stable(rstctl_q));

  assert_nvf_keep_R9: assert property (@(posedge clk) disable iff (por_rst)
    rst |=> $stable(nvf_q));

  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (rst_any)
    addr_err |=> !addr_err);

  assert_prdata_hold_R2: assert property (@(posedge clk) disable iff (rst_any)
    !rd_setup |=> $stable(prdata));
endmodule

// File: tb/tb_sysreg_bank.sv
`timescale 1ns/1ps
module tb_sysreg_bank;
  localparam logic [31:0] BID = 32'h0178_0500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por_rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, led_out;
  logic        reset_req, addr_err;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sysreg_bank #(.BOARD_ID(BID)) dut (
    .clk(clk), .rst(rst), .por_rst(por_rst), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .led_out(led_out), .reset_req(reset_req), .addr_err(addr_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d,
                        output logic pulse, output logic err);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); pulse = reset_req; err = addr_err;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic err);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); err = addr_err; psel = 0; penable = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic p, e;
    bus_wr(a, d, p, e);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic e;
    bus_rd(a, d, e);
    chk(req, d, exp);
  endtask

  task automatic pulse_rst(input bit por);
    @(negedge clk); if (por) por_rst = 1; else rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0; por_rst = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset_req", {31'b0, reset_req}, 0);
    chk("R1 addr_err", {31'b0, addr_err}, 0);
    chk("R1 led_out", led_out, 0);
    rd_chk("R1 id", 12'h000, BID);
    rd_chk("R1 flags", 12'h030, 32'h3);
    rd_chk("R1 key", 12'h020, 0);
    rd_chk("R1 rstctl", 12'h040, 0);
    rd_chk("R1 cfg", 12'h028, 0);
  endtask

  task automatic t_rw;
    wr(12'h008, 32'hA5A5_0F0F);
    chk("R3 led_out", led_out, 32'hA5A5_0F0F);
    rd_chk("R3 led read", 12'h008, 32'hA5A5_0F0F);
    wr(12'h028, 32'h1111_2222);
    wr(12'h02C, 32'h3333_4444);
    rd_chk("R4 cfg a", 12'h028, 32'h1111_2222);
    rd_chk("R4 cfg b", 12'h02C, 32'h3333_4444);
    rd_chk("R2 id back-to-back", 12'h000, BID);
  endtask

  task automatic t_lock_rst;
    logic p, e;
    wr(12'h020, 32'h0000_1234);
    rd_chk("R5 plain", 12'h020, 32'h1234);
    wr(12'h020, 32'h0000_FFFF);
    rd_chk("R5 bit15 forced", 12'h020, 32'h7FFF);
    wr(12'h020, 32'h0001_A05F);
    rd_chk("R5 upper bits", 12'h020, 32'h205F);
    bus_wr(12'h040, 32'h0000_0100, p, e);
    chk("R7 no pulse locked", {31'b0, p}, 0);
    rd_chk("R6 locked ignored", 12'h040, 0);
    wr(12'h020, 32'h0000_A05F);
    rd_chk("R5 key", 12'h020, 32'hA05F);
    bus_wr(12'h040, 32'h0000_01FF, p, e);
    chk("R7 pulse", {31'b0, p}, 1);
    @(negedge clk);
    chk("R7 pulse ends", {31'b0, reset_req}, 0);
    rd_chk("R6 stored", 12'h040, 32'h1FF);
    bus_wr(12'h040, 32'h0000_00AA, p, e);
    chk("R7 no pulse bit8 clear", {31'b0, p}, 0);
    rd_chk("R6 stored2", 12'h040, 32'hAA);
    wr(12'h020, 32'h0);
    bus_wr(12'h040, 32'h0000_0155, p, e);
    chk("R7 no pulse relocked", {31'b0, p}, 0);
    rd_chk("R6 relocked ignored", 12'h040, 32'hAA);
  endtask

  task automatic t_flags;
    wr(12'h030, 32'h0000_0030);
    rd_chk("R8 set", 12'h030, 32'h33);
    wr(12'h034, 32'h0000_0011);
    rd_chk("R8 clear", 12'h030, 32'h22);
    rd_chk("R10 clr addr reads 0", 12'h034, 0);
    wr(12'h038, 32'h0000_00C5);
    wr(12'h03C, 32'h0000_0041);
    rd_chk("R9 nv set/clear", 12'h038, 32'h84);
    pulse_rst(0);
    rd_chk("R9 nv kept on rst", 12'h038, 32'h84);
    rd_chk("R1 flags after rst", 12'h030, 32'h3);
    rd_chk("R1 led after rst", 12'h008, 0);
    pulse_rst(1);
    rd_chk("R9 nv cleared on por", 12'h038, 0);
  endtask

  task automatic t_consts;
    logic [31:0] d; logic p, e;
    rd_chk("R10 0x44", 12'h044, 32'h1);
    rd_chk("R10 0x50", 12'h050, 32'h1000);
    rd_chk("R10 0x84", 12'h084, 32'h0200_0000);
    rd_chk("R10 0x88", 12'h088, 32'hFF00_0000);
    bus_wr(12'h00C, 32'hFFFF_FFFF, p, e);
    chk("R10 no err on placeholder", {31'b0, e}, 0);
    bus_rd(12'h00C, d, e);
    chk("R10 placeholder zero", d, 0);
    wr(12'h050, 32'h0);
    rd_chk("R10 fixed unchanged", 12'h050, 32'h1000);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic p, e;
    wr(12'h008, 32'h0000_00F0);
    bus_wr(12'h078, 32'hDEAD_BEEF, p, e);
    chk("R11 err on gap write", {31'b0, e}, 1);
    @(negedge clk);
    chk("R11 err one cycle", {31'b0, addr_err}, 0);
    bus_rd(12'h078, d, e);
    chk("R11 gap reads 0", d, 0);
    chk("R11 err on gap read", {31'b0, e}, 1);
    bus_wr(12'h00A, 32'h1234_5678, p, e);
    chk("R11 err misaligned", {31'b0, e}, 1);
    rd_chk("R11 led untouched", 12'h008, 32'hF0);
    bus_wr(12'hFFC, 32'h1, p, e);
    chk("R11 err top of window", {31'b0, e}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; por_rst = 0;
    t_reset();
    t_rw();
    t_lock_rst();
    t_flags();
    t_consts();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule